// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Winner Lockout

This block picks the next owner of a shared bus from a set of masters. Priority is fixed: the master with the lowest index wins. Fixed priority on its own can keep a weak master off the bus for ever. To stop this, each master that takes the bus is locked out until none of the masters that are still unlocked is requesting. At that point every lockout drops at once, and the round starts again.

Arbitration runs while the current transfer is still on the bus. The chosen next owner is registered and held on a one-hot grant output with a valid flag. When the current owner ends its transfer it pulses `handover`, and the presented grant is taken. The arbiter then records the lockout for that winner and computes the following choice during the new transfer.

Top module: `lockout_arb`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `gnt` is all-zero, `gnt_vld` is low and no master is locked out.
- R2: When a new choice is made, the grant goes to the lowest-indexed master that is requesting and not locked out. The choice appears one clock after the inputs that produced it.
- R3: While `gnt_vld` is high and `handover` is low, `gnt` and `gnt_vld` stay unchanged, even if requests change.
- R4: A handover while `gnt_vld` is high locks out the granted master. In the same cycle a new choice is made that excludes that master, as long as some other unlocked master is requesting.
- R5: When no unlocked master is requesting, all lockouts clear in that same cycle, and a locked master that is still requesting can be chosen at once.
- R6: `gnt` is one-hot or all-zero, and `gnt_vld` is high exactly when `gnt` is non-zero.
- R7: If all masters request continuously and every grant is handed over, grants follow the order 0,1,...,N-1 and then repeat. No master is granted twice before every master has been granted once.
- R8: A `handover` pulse while `gnt_vld` is low has no effect on grants or lockouts.
- R9: With no valid grant, `gnt_vld` rises on the clock after an eligible request appears. Bit i of `gnt` stands for master i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Bus request, one bit per master |
| handover | input | 1 | Current transfer ends; the presented grant is accepted |
| gnt | output | N | One-hot next owner |
| gnt_vld | output | 1 | `gnt` holds a valid choice |

## Verification
Three things can land in one clock cycle: a handover accepting the held grant, the lockout clearing because no unlocked requester is left, and the new choice that uses both results. The bench provokes this by keeping every master requesting and handing over on every cycle, so the last master of a round is accepted in the same cycle that the locks clear. It also runs a pseudo-random sweep of request patterns and handover pulses. The outputs are compared each cycle against a model in the bench, written from the rules above.

// File: rtl/lockout_arb_pkg.sv
package lockout_arb_pkg;
    localparam int unsigned DEF_MASTERS = 4;
endpackage

// File: rtl/lkarb_pick.sv
module lkarb_pick #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] cand,
    output logic [N-1:0] pick
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign pick[i]   = cand[i] & ~seen[i];
        assign seen[i+1] = seen[i] | cand[i];
    end
endmodule

// File: rtl/lkarb_lock.sv
module lkarb_lock #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] lock_cur,
    input  logic [N-1:0] winner,
    input  logic         accept,
    input  logic [N-1:0] req,
    output logic [N-1:0] lock_nxt,
    output logic [N-1:0] elig
);
    logic [N-1:0] lock_set;
    always_comb begin
        lock_set = lock_cur | (winner & {N{accept}});
        if ((req & ~lock_set) == '0) begin
            lock_nxt = '0;
        end else begin
            lock_nxt = lock_set;
        end
        elig = req & ~lock_nxt;
    end
endmodule

// File: rtl/lockout_arb.sv
module lockout_arb #(
    parameter int unsigned N = lockout_arb_pkg::DEF_MASTERS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         handover,
    output logic [N-1:0] gnt,
    output logic         gnt_vld
);
    typedef struct packed {
        logic [N-1:0] lock;
        logic [N-1:0] gnt;
        logic         vld;
    } st_t;

    st_t st_d, st_q;
    logic         accept;
    logic [N-1:0] lock_nxt, elig, pick;
    logic [N-1:0] lock_vec;

    assign accept = handover & st_q.vld;

    lkarb_lock #(.N(N)) u_lock (
        .lock_cur (st_q.lock),
        .winner   (st_q.gnt),
        .accept   (accept),
        .req      (req),
        .lock_nxt (lock_nxt),
        .elig     (elig)
    );

    lkarb_pick #(.N(N)) u_pick (
        .cand (elig),
        .pick (pick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.lock = lock_nxt;
        if (!st_q.vld || accept) begin
            st_d.gnt = pick;
            st_d.vld = |elig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt      = st_q.gnt;
    assign gnt_vld  = st_q.vld;
    assign lock_vec = st_q.lock;
endmodule

// File: rtl/lockout_arb_chk.sv
module lockout_arb_chk #(
    parameter int unsigned N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic         handover,
    input logic [N-1:0] gnt,
    input logic         gnt_vld,
    input logic [N-1:0] lock_vec
);
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_vld_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld == (gnt != '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !handover) |=> (gnt_vld && $stable(gnt)));

    p_winner_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && handover && ((req & ~gnt & ~lock_vec) != '0))
        |=> (gnt_vld && ((gnt & $past(gnt)) == '0)));

    p_no_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld && req != '0) |=> gnt_vld);
endmodule

bind lockout_arb lockout_arb_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .handover (handover),
    .gnt      (gnt),
    .gnt_vld  (gnt_vld),
    .lock_vec (lock_vec)
);

// File: tb/lockout_arb_test.sv
`timescale 1ns/1ps
module lockout_arb_test;
    localparam int N = 4;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         handover = 1'b0;
    logic [N-1:0] gnt;
    logic         gnt_vld;

    int errors = 0;
    int checks = 0;
    logic [N-1:0] m_lock = '0, m_gnt = '0;
    logic         m_vld = 1'b0;

    always #2.5 clk = ~clk;

    lockout_arb #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .handover(handover),
        .gnt(gnt), .gnt_vld(gnt_vld)
    );

    task automatic check(input string tag, input logic [N-1:0] eg, input logic ev);
        checks++;
        if (gnt !== eg || gnt_vld !== ev) begin
            errors++;
            $display("FAIL %s: gnt=%b vld=%b expected gnt=%b vld=%b", tag, gnt, gnt_vld, eg, ev);
        end
    endtask

    // Model of the rules, one clock step
    task automatic model(input logic [N-1:0] r, input logic h);
        logic acc;
        logic [N-1:0] la, el;
        acc = h & m_vld;
        la = m_lock | (acc ? m_gnt : '0);
        if ((r & ~la) == '0) la = '0;
        el = r & ~la;
        if (!m_vld || acc) begin
            m_gnt = el & (~el + 1'b1);
            m_vld = (el != '0);
        end
        m_lock = la;
    endtask

    // drive at negedge, clock, sample at next negedge
    task automatic step(input logic [N-1:0] r, input logic h);
        req = r;
        handover = h;
        model(r, h);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0;
        handover = 1'b0;
        m_lock = '0; m_gnt = '0; m_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        check("R1 reset state", '0, 1'b0);
        step('0, 1'b0);
        check("R1 idle after reset", '0, 1'b0);

        // R2 priority: masters 1 and 3 request, 1 wins
        step(4'b1010, 1'b0);
        check("R2 lowest index wins / R9 one-cycle latency", 4'b0010, 1'b1);
        // R3 hold while master 0 arrives
        step(4'b1011, 1'b0);
        check("R3 grant held without handover", 4'b0010, 1'b1);
        // R4 handover: master 1 locked, 0 now chosen
        step(4'b1011, 1'b1);
        check("R4 handover picks master 0", 4'b0001, 1'b1);
        step(4'b1011, 1'b1);
        check("R4 winners locked, master 3 next", 4'b1000, 1'b1);
        // R5: after 3 accepted, all locked -> clear, master 0 again
        step(4'b1011, 1'b1);
        check("R5 lockouts clear at once", 4'b0001, 1'b1);

        // R8 handover without valid grant
        do_reset();
        step('0, 1'b1);
        check("R8 handover ignored when idle", '0, 1'b0);
        step(4'b0100, 1'b0);
        check("R8 no lockout from stray handover", 4'b0100, 1'b1);

        // R7 fairness, every master requesting, handover each cycle
        do_reset();
        step(4'b1111, 1'b0);
        check("R7 first grant", 4'b0001, 1'b1);
        for (int k = 0; k < 3 * N; k++) begin
            step(4'b1111, 1'b1);
            check("R7 round order", 4'(1 << ((k + 1) % N)), 1'b1);
        end

        // R5 sole locked requester is re-chosen immediately
        do_reset();
        step(4'b0001, 1'b0);
        step(4'b0001, 1'b1);
        check("R5 sole requester re-chosen", 4'b0001, 1'b1);

        // Exhaustive request patterns held, then handed over
        do_reset();
        for (int p = 0; p < 16; p++) begin
            step(4'(p), 1'b0);
            check("R2/R9 pattern hold", m_gnt, m_vld);
            step(4'(p), 1'b1);
            check("R4/R5 pattern handover", m_gnt, m_vld);
        end

        // Pseudo-random sweep against the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0], lfsr[7]);
            check("R2/R3/R4/R5/R6/R8 sweep", m_gnt, m_vld);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule